// File: doc/BRIEF.md
# Serial Receive Data Queue with Per-Frame Status

This block sits behind the shift register of an asynchronous serial receiver. Each time the shift register finishes a frame, it hands over a data byte, a ninth data bit, a framing-error flag and a parity-error flag. The block queues that frame, together with its own status, in a small circular FIFO of two entries. When both entries are occupied, the shift register itself becomes a third storage level. A completed frame waits there until a free slot opens or until the next start bit arrives. In the second case the held frame is lost.

Software sees only the oldest queued entry. It reads the status word first and then the data word. The data read is a pop strobe: it discards the head entry together with its status. When a held frame is lost, an overrun mark is kept pending. That mark is written into the status of the next frame that enters the FIFO, so every error indication stays with the byte it belongs to. Dropping the receiver enable empties everything at once.

Top module: `rxq_buffer`

## Requirements
- R1: After reset, `rx_ready` is 0 and `status_word` reads 0.
- R2: A frame offered with `frm_valid` while a slot is free is visible from the next cycle. `rx_ready` is 1, `data_word` carries the byte and `status_word` carries its flags with bit 0 = ninth data bit, bit 1 = framing error, bit 2 = parity error and bit 3 = overrun.
- R3: Queued frames are returned strictly oldest first, and each status word stays matched to its own byte across pointer wrap-around.
- R4: With both FIFO entries full, a further completed frame is held in the shift-register level and is not lost. Three back-to-back frames therefore survive with no read in between.
- R5: A cycle with `data_rd` high and `rx_ready` high removes the head entry, and its status disappears with it. From the next cycle the following entry, or an empty queue, is shown.
- R6: When a frame is held and the head is popped, the held frame enters the FIFO on that same clock, so the queue stays full.
- R7: A `start_seen` pulse while both entries are full, a frame is held and no pop occurs discards the held frame. The next frame to enter the FIFO then carries the overrun bit, and only that frame does.
- R8: A `start_seen` pulse while no frame is held changes nothing that can be observed.
- R9: `data_rd` while the queue is empty has no effect.
- R10: While `rx_en` is 0, the queue, the held frame and a pending overrun are all cleared, and incoming frames and strobes are ignored.
- R11: When `start_seen` and a pop fall in the same cycle with a frame held, the held frame moves into the FIFO and no overrun is recorded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_en | input | 1 | Receiver enable; low flushes all storage |
| frm_valid | input | 1 | One-cycle strobe: shift register completed a frame |
| frm_data | input | DATA_W | Completed data byte |
| frm_bit8 | input | 1 | Ninth data bit of the completed frame |
| frm_ferr | input | 1 | Framing error of the completed frame |
| frm_perr | input | 1 | Parity error of the completed frame |
| start_seen | input | 1 | One-cycle strobe: a new start bit was detected |
| data_rd | input | 1 | Software data read; pops the head entry |
| rx_ready | output | 1 | At least one unread entry is queued |
| data_word | output | DATA_W | Data byte of the head entry |
| status_word | output | 4 | Status of the head entry: {overrun, parity, framing, ninth bit} |

## Verification
The critical collision is a software pop in the same cycle as a start-bit detection while the FIFO is full and a frame is held. The pop frees the slot that would save the held frame, and the start bit would destroy it. The bench fills the queue with three frames and raises both strobes on one edge. It then reads the remaining entries and requires the third byte to arrive with a clear overrun bit. A second test removes the pop from that edge and requires the frame that follows to carry the overrun bit instead.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  localparam int ST_W    = 4;
  localparam int ST_OVR  = 3;
  localparam int ST_PERR = 2;
  localparam int ST_FERR = 1;
  localparam int ST_BIT8 = 0;

  typedef struct packed {
    logic ovr;
    logic perr;
    logic ferr;
    logic bit8;
  } rxq_status_t;

  function automatic rxq_status_t mk_status(input logic ovr, input logic perr,
                                            input logic ferr, input logic bit8);
    rxq_status_t s;
    s.ovr  = ovr;
    s.perr = perr;
    s.ferr = ferr;
    s.bit8 = bit8;
    return s;
  endfunction
endpackage

// File: rtl/rxq_ring.sv
module rxq_ring #(
  parameter int DEPTH = 2,
  parameter int W     = 12,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          wr_en,
  input  logic [W-1:0]  wr_entry,
  input  logic          rd_en,
  output logic [W-1:0]  head,
  output logic [CW-1:0] cnt
);
  logic [W-1:0]     slot [DEPTH];
  logic [PW-1:0]    wp, rp;
  logic [DEPTH-1:0] slot_we;

  function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  for (genvar g = 0; g < DEPTH; g++) begin : g_we
    assign slot_we[g] = wr_en && (wp == PW'(g));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) slot[i] <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++)
        if (slot_we[i]) slot[i] <= wr_entry;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else if (flush) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (wr_en) wp <= ptr_inc(wp);
      if (rd_en) rp <= ptr_inc(rp);
      case ({wr_en, rd_en})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  assign head = slot[rp];
endmodule

// File: rtl/rxq_hold.sv
module rxq_hold #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flush,
  input  logic         load,
  input  logic [W-1:0] load_entry,
  input  logic         vacate,
  output logic         vld,
  output logic [W-1:0] entry
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld   <= 1'b0;
      entry <= '0;
    end else if (flush) begin
      vld   <= 1'b0;
    end else if (load) begin
      vld   <= 1'b1;
      entry <= load_entry;
    end else if (vacate) begin
      vld   <= 1'b0;
    end
  end
endmodule

// File: rtl/rxq_buffer.sv
module rxq_buffer
  import rxq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_en,
  input  logic              frm_valid,
  input  logic [DATA_W-1:0] frm_data,
  input  logic              frm_bit8,
  input  logic              frm_ferr,
  input  logic              frm_perr,
  input  logic              start_seen,
  input  logic              data_rd,
  output logic              rx_ready,
  output logic [DATA_W-1:0] data_word,
  output logic [ST_W-1:0]   status_word
);
  localparam int ENT_W = ST_W + DATA_W;
  localparam int CW    = $clog2(DEPTH + 1);

  logic [CW-1:0]    fifo_cnt;
  logic             hold_vld;
  logic             ovr_pend;
  logic [ENT_W-1:0] hold_entry, head, in_entry, sel_entry, wr_entry;

  // named internal events
  logic flush, full;
  logic ev_pop, ev_xfer, ev_in, ev_push_in, ev_load, ev_drop, ev_push;

  assign flush      = !rx_en;
  assign full       = (fifo_cnt == CW'(DEPTH));
  assign ev_pop     = rx_en && data_rd && (fifo_cnt != '0);
  assign ev_xfer    = hold_vld && ev_pop;
  assign ev_in      = rx_en && frm_valid;
  assign ev_push_in = ev_in && !hold_vld && (!full || ev_pop);
  assign ev_load    = ev_in && !ev_push_in;
  assign ev_drop    = rx_en && hold_vld && !ev_xfer && (start_seen || frm_valid);
  assign ev_push    = ev_xfer || ev_push_in;

  assign in_entry  = {mk_status(1'b0, frm_perr, frm_ferr, frm_bit8), frm_data};
  assign sel_entry = ev_xfer ? hold_entry : in_entry;
  assign wr_entry  = {sel_entry[ENT_W-1] | ovr_pend, sel_entry[ENT_W-2:0]};

  rxq_ring #(.DEPTH(DEPTH), .W(ENT_W)) u_ring (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (flush),
    .wr_en    (ev_push),
    .wr_entry (wr_entry),
    .rd_en    (ev_pop),
    .head     (head),
    .cnt      (fifo_cnt)
  );

  rxq_hold #(.W(ENT_W)) u_hold (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush      (flush),
    .load       (ev_load),
    .load_entry (in_entry),
    .vacate     (ev_xfer || ev_drop),
    .vld        (hold_vld),
    .entry      (hold_entry)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ovr_pend <= 1'b0;
    else if (flush)   ovr_pend <= 1'b0;
    else if (ev_drop) ovr_pend <= 1'b1;
    else if (ev_push) ovr_pend <= 1'b0;
  end

  assign rx_ready    = (fifo_cnt != '0);
  assign data_word   = head[DATA_W-1:0];
  assign status_word = rx_ready ? head[ENT_W-1:DATA_W] : '0;
endmodule

// File: rtl/rxq_buffer_chk.sv
module rxq_buffer_chk #(
  parameter int DEPTH = 2,
  parameter int CW    = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rx_en,
  input logic          data_rd,
  input logic          start_seen,
  input logic          frm_valid,
  input logic          rx_ready,
  input logic [CW-1:0] fifo_cnt,
  input logic          hold_vld,
  input logic          ovr_pend
);
  a_r4_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_cnt <= CW'(DEPTH));

  a_r4_hold_only_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    hold_vld |-> fifo_cnt == CW'(DEPTH));

  a_r5_pop_shrinks: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_en && data_rd && rx_ready && !hold_vld && !frm_valid)
      |=> fifo_cnt == $past(fifo_cnt) - 1'b1);

  a_r6_xfer_keeps_full: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_en && data_rd && hold_vld) |=> fifo_cnt == CW'(DEPTH));

  a_r7_drop_marks_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_en && start_seen && hold_vld && !data_rd && !frm_valid)
      |=> (ovr_pend && !hold_vld));

  a_r9_empty_read_inert: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_en && data_rd && !rx_ready && !frm_valid) |=> !rx_ready);

  a_r10_disable_flushes: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> (!rx_ready && !hold_vld && !ovr_pend));

  a_r11_no_overrun_on_pop: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_en && start_seen && data_rd && hold_vld && !ovr_pend) |=> !ovr_pend);
endmodule

bind rxq_buffer rxq_buffer_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rx_en      (rx_en),
  .data_rd    (data_rd),
  .start_seen (start_seen),
  .frm_valid  (frm_valid),
  .rx_ready   (rx_ready),
  .fifo_cnt   (fifo_cnt),
  .hold_vld   (hold_vld),
  .ovr_pend   (ovr_pend)
);

// File: tb/rxq_buffer_tb.sv
module rxq_buffer_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_en = 1'b0;
  logic       frm_valid = 1'b0;
  logic [7:0] frm_data = '0;
  logic       frm_bit8 = 1'b0, frm_ferr = 1'b0, frm_perr = 1'b0;
  logic       start_seen = 1'b0;
  logic       data_rd = 1'b0;
  logic       rx_ready;
  logic [7:0] data_word;
  logic [3:0] status_word;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  always #2 clk = ~clk;

  rxq_buffer #(.DATA_W(8), .DEPTH(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .frm_valid(frm_valid),
    .frm_data(frm_data), .frm_bit8(frm_bit8), .frm_ferr(frm_ferr),
    .frm_perr(frm_perr), .start_seen(start_seen), .data_rd(data_rd),
    .rx_ready(rx_ready), .data_word(data_word), .status_word(status_word)
  );

  // status encoding per R2: {overrun, parity, framing, ninth bit}
  function automatic logic [3:0] st(input logic ovr, input logic pe,
                                    input logic fe, input logic b8);
    return {ovr, pe, fe, b8};
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic send(input logic [7:0] d, input logic b8, input logic fe, input logic pe);
    frm_valid = 1'b1; frm_data = d; frm_bit8 = b8; frm_ferr = fe; frm_perr = pe;
    tick();
    frm_valid = 1'b0;
  endtask

  task automatic start_bit();
    start_seen = 1'b1;
    tick();
    start_seen = 1'b0;
  endtask

  task automatic read_head(input string req, input logic [7:0] d, input logic [3:0] s);
    check(req, rx_ready, 1);
    check(req, status_word, s);
    check(req, data_word, d);
    data_rd = 1'b1;
    tick();
    data_rd = 1'b0;
  endtask

  task automatic fill_three();
    start_bit(); send(8'h11, 1'b0, 1'b0, 1'b0);
    start_bit(); send(8'h22, 1'b1, 1'b1, 1'b0);
    start_bit(); send(8'h33, 1'b0, 1'b0, 1'b1);
  endtask

  task automatic t_reset();
    check("R1 ready", rx_ready, 0);
    check("R1 status", status_word, 0);
  endtask

  task automatic t_single();
    send(8'hA5, 1'b1, 1'b0, 1'b1);
    read_head("R2 single", 8'hA5, st(1'b0, 1'b1, 1'b0, 1'b1));
    check("R5 empty after pop", rx_ready, 0);
  endtask

  task automatic t_three_stalled();
    fill_three();
    check("R4 ready while stalled", rx_ready, 1);
    read_head("R3 first", 8'h11, st(1'b0, 1'b0, 1'b0, 1'b0));
    check("R6 still ready", rx_ready, 1);
    read_head("R3 second", 8'h22, st(1'b0, 1'b0, 1'b1, 1'b1));
    read_head("R4 held frame", 8'h33, st(1'b0, 1'b1, 1'b0, 1'b0));
    check("R5 drained", rx_ready, 0);
  endtask

  task automatic t_overrun();
    fill_three();
    start_bit();                       // fourth start bit: held 0x33 lost
    send(8'h44, 1'b1, 1'b0, 1'b0);     // goes to shift-register level
    read_head("R7 first clean", 8'h11, st(1'b0, 1'b0, 1'b0, 1'b0));
    read_head("R7 second clean", 8'h22, st(1'b0, 1'b0, 1'b1, 1'b1));
    read_head("R7 overrun tagged", 8'h44, st(1'b1, 1'b0, 1'b0, 1'b1));
    check("R7 drained", rx_ready, 0);
    send(8'h55, 1'b0, 1'b0, 1'b0);
    read_head("R7 tag used once", 8'h55, st(1'b0, 1'b0, 1'b0, 1'b0));
  endtask

  task automatic t_start_free();
    send(8'h66, 1'b0, 1'b1, 1'b0);
    start_bit();
    start_bit();
    read_head("R8 no effect", 8'h66, st(1'b0, 1'b0, 1'b1, 1'b0));
    check("R8 drained", rx_ready, 0);
  endtask

  task automatic t_empty_read();
    data_rd = 1'b1; tick(); tick(); data_rd = 1'b0;
    check("R9 still empty", rx_ready, 0);
    send(8'h77, 1'b0, 1'b0, 1'b0);
    read_head("R9 next frame intact", 8'h77, st(1'b0, 1'b0, 1'b0, 1'b0));
    check("R9 single entry", rx_ready, 0);
  endtask

  task automatic t_same_cycle();
    fill_three();
    check("R11 head", data_word, 8'h11);
    start_seen = 1'b1; data_rd = 1'b1;
    tick();
    start_seen = 1'b0; data_rd = 1'b0;
    read_head("R11 second", 8'h22, st(1'b0, 1'b0, 1'b1, 1'b1));
    read_head("R11 held survives", 8'h33, st(1'b0, 1'b1, 1'b0, 1'b0));
    check("R11 drained", rx_ready, 0);
  endtask

  task automatic t_disable();
    fill_three();
    start_bit();                       // overrun pending
    rx_en = 1'b0; tick();
    check("R10 flushed", rx_ready, 0);
    send(8'h88, 1'b0, 1'b0, 1'b0);
    check("R10 ignored while off", rx_ready, 0);
    rx_en = 1'b1; tick();
    check("R10 empty on re-enable", rx_ready, 0);
    send(8'h99, 1'b0, 1'b0, 1'b0);
    read_head("R10 pending overrun cleared", 8'h99, st(1'b0, 1'b0, 1'b0, 1'b0));
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    tick(); tick();
    t_reset();
    rst_n = 1'b1;
    tick();
    rx_en = 1'b1;
    tick();
    t_single();
    t_three_stalled();
    t_overrun();
    t_start_free();
    t_empty_read();
    t_same_cycle();
    t_disable();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end
endmodule